// File: doc/BRIEF.md
# Vector AES-128 Next-Round-Key Unit

This unit takes a vector of 128-bit AES-128 round keys, each held in a group of four 32-bit elements, and writes the next round key of the schedule into a destination vector. A 4-bit round selector picks the round constant. Round selectors outside 1 to 10 are not rejected: bit 3 of the selector is flipped to bring them into range. For each active group the unit builds a temporary word from the last key word by rotating it right by 8 bits, which is RotWord when byte 0 sits in the low bits. It passes each byte of that word through the AES forward S-box and XORs the result and the round constant into word 0. The remaining three words are then formed as a chain of XORs.

The caller supplies the current destination contents, the element count, the start element and a tail-agnostic flag. Groups below the start element keep their old contents. Groups from the start element up to the element count receive new keys. Elements at or beyond the element count keep their old contents, or become all ones when the tail-agnostic flag is set. If the element count or the start element is not a multiple of four, the unit reports an illegal operation, writes nothing and leaves the start index unchanged. Otherwise the start index it reports is zero. The results are registered and appear one cycle after the request.

Top module: `kexp_step_vec`

## Requirements
- R1: Only bits [3:0] of `in_round` are used. A value of 0, or of 11 to 15, has bit 3 inverted to give the effective round (0→8, 11→3, 12→4, 13→5, 14→6, 15→7). Values 1 to 10 are used as they are.
- R2: The round constant for effective round r is the r-th entry of the sequence 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x40, 0x80, 0x1B, 0x36. It is placed in bits [7:0] of a 32-bit word whose upper bits are zero.
- R3: Element j (0..3) of group g lies at bits [(4g+j)*32 +: 32] of `in_src` and `out_dst`, and byte k of a word lies at bits [8k +: 8]. New word 0 equals source word 0 XOR S(rotr8(word 3)) XOR the round constant. S applies the AES forward S-box to each byte separately.
- R4: For j = 1, 2 and 3, new word j equals source word j XOR new word j-1.
- R5: In a legal operation, elements with an index below `in_start` and below `in_len` keep the value they have in `in_dst`.
- R6: In a legal operation, an element whose index is at least `in_len` becomes 0xFFFFFFFF when `in_tail_agn` is 1 and keeps its `in_dst` value when it is 0.
- R7: If `in_len` or `in_start` is not a multiple of 4, the unit sets `out_illegal` to 1 and `out_we` to 0. In that case `out_dst` equals `in_dst` and `out_start` equals `in_start`.
- R8: A legal operation gives `out_we` = 1, `out_illegal` = 0 and `out_start` = 0.
- R9: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` = 1. While `out_valid` is 0, `out_we` and `out_illegal` are 0.
- R10: While reset is asserted and right after it, `out_valid`, `out_we`, `out_illegal`, `out_start` and `out_dst` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe, one operation per cycle |
| in_src | input | GROUPS*128 | Source round keys, one per group |
| in_dst | input | GROUPS*128 | Current destination contents |
| in_round | input | 4 | Round selector |
| in_len | input | CNT_W | Element count |
| in_start | input | CNT_W | First element to process |
| in_tail_agn | input | 1 | Fill tail elements with ones when 1 |
| out_valid | output | 1 | Result strobe |
| out_we | output | 1 | Destination write enable |
| out_illegal | output | 1 | Misaligned count or start |
| out_start | output | CNT_W | Start index after the operation |
| out_dst | output | GROUPS*128 | New destination contents |

## Verification
Zero keys give known answers at rounds 1, 0 and 11. These show whether the S-box, the byte rotation, the round constant and the bit-3 remap are right without any reference table. Random keys run at all sixteen selector values, and that separates each round constant and the XOR chain from a constant-only fault. Start and length are varied: partial start, short length with the tail flag both set and clear, start at or past length, zero length, and misaligned values of each. These cases show whether the old-versus-new-versus-ones choice for each element and the no-write path are handled correctly.

// File: rtl/kexp_pkg.sv
package kexp_pkg;
   localparam int WORD_W    = 32;
   localparam int BYTE_W    = 8;
   localparam int GRP_WORDS = 4;
   localparam int KEY_W     = WORD_W * GRP_WORDS;
   localparam int GRP_SHIFT = $clog2(GRP_WORDS);
   localparam int RND_W     = 4;
   localparam int MAX_ROUND = 10;

   // multiply in GF(2^8) modulo x^8+x^4+x^3+x+1
   function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] x;
      acc = 8'h00;
      x   = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ x;
         x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
      end
      return acc;
   endfunction

   // inverse as a^254 (zero maps to zero)
   function automatic logic [7:0] gf_inv(input logic [7:0] a);
      logic [7:0] r;
      r = a;
      for (int i = 0; i < 6; i++) r = gf_mul(gf_mul(r, r), a);
      return gf_mul(r, r);
   endfunction

   function automatic logic [7:0] sbox_fwd(input logic [7:0] b);
      logic [7:0] v;
      v = gf_inv(b);
      return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
               ^ {v[3:0], v[7:4]} ^ 8'h63;
   endfunction

   function automatic logic [7:0] rcon_byte(input logic [RND_W-1:0] r);
      case (r)
         4'd1:    return 8'h01;
         4'd2:    return 8'h02;
         4'd3:    return 8'h04;
         4'd4:    return 8'h08;
         4'd5:    return 8'h10;
         4'd6:    return 8'h20;
         4'd7:    return 8'h40;
         4'd8:    return 8'h80;
         4'd9:    return 8'h1b;
         4'd10:   return 8'h36;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/kexp_round_fix.sv
module kexp_round_fix
   import kexp_pkg::*;
#(
   parameter int IMM_W = RND_W
) (
   input  logic [IMM_W-1:0]  imm,
   output logic [WORD_W-1:0] rcon_w
);
   if (IMM_W < RND_W) begin : g_bad_imm
      $error("kexp_round_fix: IMM_W must be at least 4");
   end

   logic [RND_W-1:0] low;
   logic             flip;
   logic [RND_W-1:0] eff;

   assign low  = imm[RND_W-1:0];
   assign flip = (low == '0) || (low > RND_W'(MAX_ROUND));
   assign eff  = low ^ {flip, {(RND_W-1){1'b0}}};

   assign rcon_w = {{(WORD_W-BYTE_W){1'b0}}, rcon_byte(eff)};
endmodule

// File: rtl/kexp_group_step.sv
module kexp_group_step
   import kexp_pkg::*;
(
   input  logic [KEY_W-1:0]  key_in,
   input  logic [WORD_W-1:0] rcon_w,
   output logic [KEY_W-1:0]  key_out
);
   localparam int NBYTES = WORD_W / BYTE_W;

   logic [GRP_WORDS-1:0][WORD_W-1:0] w;
   logic [GRP_WORDS-1:0][WORD_W-1:0] n;
   logic [WORD_W-1:0]                rot;
   logic [WORD_W-1:0]                sub;

   assign w   = key_in;
   assign rot = {w[GRP_WORDS-1][BYTE_W-1:0], w[GRP_WORDS-1][WORD_W-1:BYTE_W]};

   for (genvar b = 0; b < NBYTES; b++) begin : g_sbox
      assign sub[b*BYTE_W +: BYTE_W] = sbox_fwd(rot[b*BYTE_W +: BYTE_W]);
   end

   assign n[0] = w[0] ^ sub ^ rcon_w;
   for (genvar j = 1; j < GRP_WORDS; j++) begin : g_chain
      assign n[j] = w[j] ^ n[j-1];
   end

   assign key_out = n;
endmodule

// File: rtl/kexp_elem_select.sv
module kexp_elem_select
   import kexp_pkg::*;
#(
   parameter int ELEM_IDX = 0,
   parameter int CNT_W    = 8
) (
   input  logic              legal,
   input  logic              tail_agn,
   input  logic [CNT_W-1:0]  len,
   input  logic [CNT_W-1:0]  start,
   input  logic [WORD_W-1:0] old_e,
   input  logic [WORD_W-1:0] new_e,
   output logic [WORD_W-1:0] res_e
);
   localparam logic [CNT_W-1:0] IDX = CNT_W'(ELEM_IDX);

   always_comb begin
      if (!legal) begin
         res_e = old_e;
      end else if (IDX >= len) begin
         res_e = tail_agn ? {WORD_W{1'b1}} : old_e;
      end else if (IDX >= start) begin
         res_e = new_e;
      end else begin
         res_e = old_e;
      end
   end
endmodule

// File: rtl/kexp_step_vec.sv
module kexp_step_vec
   import kexp_pkg::*;
#(
   parameter int GROUPS = 4,
   parameter int CNT_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [GROUPS*KEY_W-1:0] in_src,
   input  logic [GROUPS*KEY_W-1:0] in_dst,
   input  logic [RND_W-1:0]        in_round,
   input  logic [CNT_W-1:0]        in_len,
   input  logic [CNT_W-1:0]        in_start,
   input  logic                    in_tail_agn,
   output logic                    out_valid,
   output logic                    out_we,
   output logic                    out_illegal,
   output logic [CNT_W-1:0]        out_start,
   output logic [GROUPS*KEY_W-1:0] out_dst
);
   localparam int ELEMS = GROUPS * GRP_WORDS;
   localparam int VEC_W = GROUPS * KEY_W;

   if (GROUPS < 1) begin : g_bad_groups
      $error("kexp_step_vec: GROUPS must be at least 1");
   end
   if (CNT_W <= GRP_SHIFT || (2 ** CNT_W) <= ELEMS) begin : g_bad_cnt
      $error("kexp_step_vec: CNT_W too narrow for the element count");
   end

   logic              legal;
   logic [WORD_W-1:0] rcon_w;
   logic [VEC_W-1:0]  next_keys;
   logic [VEC_W-1:0]  sel_dst;

   assign legal = (in_len[GRP_SHIFT-1:0] == '0) && (in_start[GRP_SHIFT-1:0] == '0);

   kexp_round_fix #(.IMM_W(RND_W)) u_round (
      .imm    (in_round),
      .rcon_w (rcon_w)
   );

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      kexp_group_step u_step (
         .key_in  (in_src[g*KEY_W +: KEY_W]),
         .rcon_w  (rcon_w),
         .key_out (next_keys[g*KEY_W +: KEY_W])
      );
      for (genvar j = 0; j < GRP_WORDS; j++) begin : g_elem
         localparam int E = g * GRP_WORDS + j;
         kexp_elem_select #(.ELEM_IDX(E), .CNT_W(CNT_W)) u_sel (
            .legal    (legal),
            .tail_agn (in_tail_agn),
            .len      (in_len),
            .start    (in_start),
            .old_e    (in_dst[E*WORD_W +: WORD_W]),
            .new_e    (next_keys[E*WORD_W +: WORD_W]),
            .res_e    (sel_dst[E*WORD_W +: WORD_W])
         );
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_we      <= 1'b0;
         out_illegal <= 1'b0;
         out_start   <= '0;
         out_dst     <= '0;
      end else begin
         out_valid   <= in_valid;
         out_we      <= in_valid & legal;
         out_illegal <= in_valid & ~legal;
         if (in_valid) begin
            out_start <= legal ? '0 : in_start;
            out_dst   <= sel_dst;
         end
      end
   end
endmodule

// File: rtl/kexp_step_vec_chk.sv
module kexp_step_vec_chk
   import kexp_pkg::*;
#(
   parameter int GROUPS = 4,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [KEY_W-1:0]  in_dst_lo,
   input logic [CNT_W-1:0]  in_len,
   input logic [CNT_W-1:0]  in_start,
   input logic              in_tail_agn,
   input logic              out_valid,
   input logic              out_we,
   input logic              out_illegal,
   input logic [CNT_W-1:0]  out_start,
   input logic [KEY_W-1:0]  out_dst_lo,
   input logic [WORD_W-1:0] out_dst_hi
);
   localparam int ELEMS = GROUPS * GRP_WORDS;

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !out_we && !out_illegal));
   a_r7_illegal_detect: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_len[1:0] != 2'b00 || in_start[1:0] != 2'b00))
      |=> (out_illegal && !out_we && out_start == $past(in_start)));
   a_r8_legal_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_illegal) |-> (out_we && out_start == '0));
   a_r5_prestart_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_len[1:0] == 2'b00 && in_start[1:0] == 2'b00
       && in_start >= CNT_W'(GRP_WORDS) && in_len >= CNT_W'(GRP_WORDS))
      |=> (out_dst_lo == $past(in_dst_lo)));
   a_r6_tail_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_len[1:0] == 2'b00 && in_start[1:0] == 2'b00
       && in_tail_agn && in_len < CNT_W'(ELEMS))
      |=> (out_dst_hi == {WORD_W{1'b1}}));
endmodule

bind kexp_step_vec kexp_step_vec_chk #(.GROUPS(GROUPS), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_dst_lo   (in_dst[kexp_pkg::KEY_W-1:0]),
   .in_len      (in_len),
   .in_start    (in_start),
   .in_tail_agn (in_tail_agn),
   .out_valid   (out_valid),
   .out_we      (out_we),
   .out_illegal (out_illegal),
   .out_start   (out_start),
   .out_dst_lo  (out_dst[kexp_pkg::KEY_W-1:0]),
   .out_dst_hi  (out_dst[GROUPS*kexp_pkg::KEY_W-1 -: kexp_pkg::WORD_W])
);

// File: tb/kexp_step_vec_bench.sv
module kexp_step_vec_bench;
   localparam int G  = 4;
   localparam int CW = 8;
   localparam int E  = G * 4;
   localparam int VW = G * 128;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [VW-1:0]  in_src = '0;
   logic [VW-1:0]  in_dst = '0;
   logic [3:0]     in_round = '0;
   logic [CW-1:0]  in_len = '0;
   logic [CW-1:0]  in_start = '0;
   logic           in_tail_agn = 1'b0;
   logic           out_valid, out_we, out_illegal;
   logic [CW-1:0]  out_start;
   logic [VW-1:0]  out_dst;

   int total = 0;
   int bad = 0;
   logic [7:0] sb [256];

   kexp_step_vec #(.GROUPS(G), .CNT_W(CW)) u_kexp_step_vec (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src), .in_dst(in_dst),
      .in_round(in_round), .in_len(in_len), .in_start(in_start), .in_tail_agn(in_tail_agn),
      .out_valid(out_valid), .out_we(out_we), .out_illegal(out_illegal),
      .out_start(out_start), .out_dst(out_dst)
   );

   always #4 clk = ~clk;

   initial begin
      #(8 * 200000);
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   function automatic int xt(input int v);
      int r;
      r = (v << 1) & 255;
      if ((v & 128) != 0) r = r ^ 8'h1b;
      return r;
   endfunction

   function automatic int slow_mul(input int a, input int b);
      int r = 0;
      int x = a;
      for (int i = 0; i < 8; i++) begin
         if (((b >> i) & 1) != 0) r = r ^ x;
         x = xt(x);
      end
      return r;
   endfunction

   task automatic build_sbox();
      for (int x = 0; x < 256; x++) begin
         int inv = 0;
         logic [7:0] b, s;
         for (int y = 1; y < 256; y++) if (slow_mul(x, y) == 1) inv = y;
         b = 8'(inv);
         for (int i = 0; i < 8; i++)
            s[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ ((8'h63 >> i) & 1);
         sb[x] = s;
      end
   endtask

   task automatic model(input logic [VW-1:0] src, input logic [VW-1:0] dst, input int rnd,
                        input int len, input int st, input bit tail,
                        output logic [VW-1:0] ed, output bit ill, output int est);
      int r, rc;
      logic [31:0] w [4];
      logic [31:0] nw [4];
      logic [31:0] t, s;
      r = rnd & 15;
      if (r == 0 || r > 10) r = r ^ 8;
      rc = 1;
      for (int k = 1; k < r; k++) rc = xt(rc);
      ill = ((len % 4) != 0) || ((st % 4) != 0);
      est = ill ? st : 0;
      ed = dst;
      if (!ill) begin
         for (int g = 0; g < G; g++) begin
            for (int j = 0; j < 4; j++) w[j] = src[(g*4+j)*32 +: 32];
            t = (w[3] >> 8) | (w[3] << 24);
            for (int k = 0; k < 4; k++) s[k*8 +: 8] = sb[t[k*8 +: 8]];
            nw[0] = w[0] ^ s ^ 32'(rc);
            nw[1] = w[1] ^ nw[0];
            nw[2] = w[2] ^ nw[1];
            nw[3] = w[3] ^ nw[2];
            for (int j = 0; j < 4; j++) begin
               int e = g * 4 + j;
               if (e >= len) begin
                  if (tail) ed[e*32 +: 32] = 32'hffff_ffff;
               end else if (e >= st) begin
                  ed[e*32 +: 32] = nw[j];
               end
            end
         end
      end
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [VW-1:0] act, input logic [VW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [VW-1:0] rnd_vec();
      logic [VW-1:0] v;
      for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic run_op(input logic [VW-1:0] src, input logic [VW-1:0] dst, input int rnd,
                         input int len, input int st, input bit tail, input string req);
      logic [VW-1:0] ed;
      bit ill;
      int est;
      model(src, dst, rnd, len, st, tail, ed, ill, est);
      in_src = src; in_dst = dst; in_round = 4'(rnd);
      in_len = CW'(len); in_start = CW'(st); in_tail_agn = tail; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid === 1'b1, "R9", "valid", VW'(out_valid), 1);
      chk(out_illegal === ill, ill ? "R7" : "R8", "illegal", VW'(out_illegal), VW'(ill));
      chk(out_we === !ill, ill ? "R7" : "R8", "we", VW'(out_we), VW'(!ill));
      chk(out_start === CW'(est), ill ? "R7" : "R8", "start", VW'(out_start), VW'(est));
      chk(out_dst === ed, req, "dst", out_dst, ed);
      @(negedge clk);
      chk(out_valid === 1'b0 && out_we === 1'b0 && out_illegal === 1'b0, "R9", "idle",
          VW'({out_valid, out_we, out_illegal}), 0);
   endtask

   initial begin
      logic [VW-1:0] k, d;
      build_sbox();
      @(negedge clk);
      chk(out_valid === 0 && out_we === 0 && out_illegal === 0 && out_start === 0,
          "R10", "ctrl in reset", VW'({out_valid, out_we, out_illegal, out_start}), 0);
      chk(out_dst === '0, "R10", "dst in reset", out_dst, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 0 && out_dst === '0, "R10", "after reset", out_dst, '0);

      // known answers from zero keys, R3/R4/R2 and the R1 remap
      run_op('0, '1, 1, E, 0, 1'b0, "R3");
      chk(out_dst === {E{32'h6363_6362}}, "R3", "zero key round 1", out_dst, {E{32'h6363_6362}});
      run_op('0, '1, 0, E, 0, 1'b0, "R1");
      chk(out_dst === {E{32'h6363_63e3}}, "R1", "round 0 to 8", out_dst, {E{32'h6363_63e3}});
      run_op('0, '1, 11, E, 0, 1'b0, "R1");
      chk(out_dst === {E{32'h6363_6367}}, "R1", "round 11 to 3", out_dst, {E{32'h6363_6367}});

      // every selector with random keys: R1, R2, R4
      for (int r = 0; r < 16; r++) begin
         run_op(rnd_vec(), rnd_vec(), r, E, 0, 1'b0, "R2");
      end
      for (int i = 0; i < 8; i++) run_op(rnd_vec(), rnd_vec(), 1 + i, E, 0, 1'b1, "R4");

      // partial start: R5
      run_op(rnd_vec(), rnd_vec(), 5, E, 8, 1'b0, "R5");
      run_op(rnd_vec(), rnd_vec(), 9, E, 4, 1'b1, "R5");
      run_op(rnd_vec(), rnd_vec(), 10, 8, 12, 1'b1, "R5");
      // tails: R6
      run_op(rnd_vec(), rnd_vec(), 3, 8, 0, 1'b1, "R6");
      run_op(rnd_vec(), rnd_vec(), 3, 8, 0, 1'b0, "R6");
      run_op(rnd_vec(), rnd_vec(), 7, 0, 0, 1'b1, "R6");
      run_op(rnd_vec(), rnd_vec(), 7, 4, 4, 1'b0, "R6");
      // misaligned: R7
      k = rnd_vec(); d = rnd_vec();
      run_op(k, d, 2, 6, 0, 1'b1, "R7");
      run_op(k, d, 2, E, 2, 1'b1, "R7");
      run_op(k, d, 2, 7, 5, 1'b0, "R7");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule